// File: doc/BRIEF.md
# Store Buffer with Same-Line Pair Commit

This block is a ring of store entries between the execution core and a first-level data cache. Rename allocates entries in program order. Address ports and data ports then fill them in any order. A retire count marks entries as architecturally committed. The oldest retired entries whose address and data are both present drain into the cache through a single write port, one transaction per cycle.

Each entry holds one 32-byte slot of a 64-byte line. A wide store arrives as two slots in neighbouring entries. Two back-to-back narrow stores can also land in the two halves of one line. When the two oldest entries are both ready and share a line but cover opposite halves, the block emits them as one full-line transaction. The ring then advances by two in that cycle.

A pipeline flush drops every entry that has not yet retired. Retired entries stay in the ring and drain normally.

Top module: `stbuf_merge`

## Requirements
- R1: After reset the ring is empty: `free_cnt` equals DEPTH, `alloc_tail` is 0, `cw_valid` is 0 and `alloc_stall` is 0.
- R2: Allocation is refused when `alloc_num` exceeds `free_cnt`. In that case `alloc_stall` is 1 in the same cycle, and neither `alloc_tail` nor `free_cnt` changes because of the request. Accepted entries take slot numbers `alloc_tail`, `alloc_tail`+1, and so on, modulo DEPTH.
- R3: The oldest entry is committed only when three conditions hold: it has retired, its address has been written, and its data has been written. A younger entry never commits ahead of an older entry that is not ready.
- R4: For a single commit, `cw_line` is the address bits above bit 5. Address bit 5 selects the half of the line: 0 places the slot's data in `cw_data[255:0]` and its byte mask in `cw_be[31:0]`; 1 places them in `cw_data[511:256]` and `cw_be[63:32]`. The other half is all zero, and address bits 4..0 are ignored.
- R5: When the two oldest entries are both ready, have the same line and have different half bits, they are emitted in one cycle with both halves filled. `free_cnt` then rises by 2 at the next edge.
- R6: If the second-oldest entry has the same half as the oldest, a different line, or is not ready, only the oldest entry commits in that cycle.
- R7: An integer data port carries 8 bytes, an 8-bit byte mask and a 2-bit lane select L. It places the bytes at slot bytes 8L..8L+7 and clears the rest of the slot's mask. A media port writes the whole 32-byte slot and its 32-bit mask.
- R8: A flush moves `alloc_tail` back to the slot just after the youngest retired entry. `free_cnt` regains every discarded entry, and the retired entries still commit afterwards.
- R9: Slot numbers wrap from DEPTH-1 to 0, and a same-line pair at slots DEPTH-1 and 0 still merges.
- R10: `free_cnt` reflects allocations and commits at the clock edge on which they take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_num | input | 3 | Entries requested by rename this cycle (0..4) |
| alloc_stall | output | 1 | Request exceeds free entries; nothing allocated |
| alloc_tail | output | 6 | Slot number given to the first entry allocated this cycle |
| free_cnt | output | 6 | Unoccupied entries |
| retire_num | input | 3 | Stores retiring this cycle, oldest unretired first |
| flush | input | 1 | Discard all unretired entries |
| addr_vld | input | 3 | Address write strobe per address port |
| addr_idx | input | 3x6 | Target slot per address port |
| addr_val | input | 3x48 | Byte address per address port |
| int_vld | input | 2 | Integer data write strobe |
| int_idx | input | 2x6 | Target slot per integer port |
| int_lane | input | 2x2 | 8-byte lane inside the slot |
| int_data | input | 2x64 | Integer store data |
| int_be | input | 2x8 | Integer byte mask |
| med_vld | input | 2 | Media data write strobe |
| med_idx | input | 2x6 | Target slot per media port |
| med_data | input | 2x256 | Media store data |
| med_be | input | 2x32 | Media byte mask |
| cw_valid | output | 1 | Cache write this cycle (always accepted) |
| cw_line | output | 42 | Line address of the write |
| cw_data | output | 512 | Full-line write data |
| cw_be | output | 64 | Per-byte write enable of the line |

## Verification
The hardest case to reach from the ports is a same-line pair that sits exactly across the wrap point of the ring. The bench gets there by feeding 33 single stores, one after another. Each is allocated, filled and retired until the head rests on the last slot. It then allocates a two-entry pair whose halves straddle slots 43 and 0.

A second awkward case is a flush arriving while retired entries are still incomplete. The bench fills the whole ring, retires two entries that have no data, flushes, and only then supplies their address and data. It then checks that they still merge.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int SLOT_BYTES = 32;
  localparam int LINE_BYTES = 2 * SLOT_BYTES;
  localparam int INT_BYTES  = 8;
  localparam int SLOT_BITS  = SLOT_BYTES * 8;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int INT_BITS   = INT_BYTES * 8;
  localparam int LANES      = SLOT_BYTES / INT_BYTES;
  localparam int LANE_W     = $clog2(LANES);
  localparam int HALF_LSB   = $clog2(SLOT_BYTES);
  localparam int LINE_LSB   = $clog2(LINE_BYTES);
endpackage

// File: rtl/sbm_ctrl.sv
module sbm_ctrl #(
  parameter  int DEPTH   = 44,
  parameter  int ALLOC_W = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int AN_W    = $clog2(ALLOC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AN_W-1:0]  alloc_num,
  input  logic [AN_W-1:0]  retire_num,
  input  logic             flush,
  input  logic [1:0]       commit_num,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] head1_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] ret_cnt_o,
  output logic [CNT_W-1:0] free_o,
  output logic             alloc_stall_o,
  output logic [DEPTH-1:0] alloc_clr_o
);

  logic [IDX_W-1:0] head_q, head_d, tail_q, tail_d, ret_q, ret_d;
  logic [CNT_W-1:0] used_q, used_d, ret_cnt_q, ret_cnt_d;
  logic [CNT_W-1:0] free_w, unret_w;
  logic             alloc_go, upd_en;

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] p,
                                                input int unsigned n);
    int unsigned s;
    s = 32'(p) + n;
    if (s >= 32'(DEPTH)) s = s - 32'(DEPTH);
    return s[IDX_W-1:0];
  endfunction

  always_comb begin
    free_w   = CNT_W'(DEPTH) - used_q;
    unret_w  = used_q - ret_cnt_q;
    alloc_stall_o = CNT_W'(alloc_num) > free_w;
    alloc_go = !alloc_stall_o && !flush && (alloc_num != '0);

    head_d    = wrap_add(head_q, 32'(commit_num));
    ret_d     = wrap_add(ret_q, 32'(retire_num));
    ret_cnt_d = ret_cnt_q + CNT_W'(retire_num) - CNT_W'(commit_num);
    if (flush) begin
      tail_d = ret_d;
      used_d = ret_cnt_d;
    end else begin
      tail_d = alloc_go ? wrap_add(tail_q, 32'(alloc_num)) : tail_q;
      used_d = used_q - CNT_W'(commit_num) + (alloc_go ? CNT_W'(alloc_num) : '0);
    end

    alloc_clr_o = '0;
    for (int k = 0; k < ALLOC_W; k++) begin
      if (alloc_go && (k < int'(alloc_num))) alloc_clr_o[wrap_add(tail_q, 32'(k))] = 1'b1;
    end

    upd_en = alloc_go || flush || (retire_num != '0) || (commit_num != 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      ret_q     <= '0;
      used_q    <= '0;
      ret_cnt_q <= '0;
    end else if (upd_en) begin
      head_q    <= head_d;
      tail_q    <= tail_d;
      ret_q     <= ret_d;
      used_q    <= used_d;
      ret_cnt_q <= ret_cnt_d;
    end
  end

  assign head_o    = head_q;
  assign head1_o   = wrap_add(head_q, 32'd1);
  assign tail_o    = tail_q;
  assign ret_cnt_o = ret_cnt_q;
  assign free_o    = free_w;

  // R2: occupancy never exceeds the ring size
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CNT_W'(DEPTH));
  // R2: a refused request leaves the allocation point where it was
  a_r2_stall_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_stall_o && !flush) |=> tail_q == $past(tail_q));
  // R3: the selector never drains more entries than have retired
  a_r3_commit_retired: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(commit_num) <= ret_cnt_q);
  // R3: retirement never runs past allocated entries
  a_r3_retire_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(retire_num) <= unret_w);
  // R8: after a flush only retired entries remain
  a_r8_flush_keeps_retired: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> used_q == ret_cnt_q);
  // R9: pointers stay inside the ring
  a_r9_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(head_q) < 32'(DEPTH)) && (32'(tail_q) < 32'(DEPTH)));

endmodule

// File: rtl/sbm_store.sv
module sbm_store import sbm_pkg::*; #(
  parameter  int DEPTH  = 44,
  parameter  int ADDR_W = 48,
  parameter  int NA     = 3,
  parameter  int NI     = 2,
  parameter  int NM     = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LINE_W = ADDR_W - LINE_LSB
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [DEPTH-1:0]                alloc_clr,
  input  logic [NA-1:0]                   addr_vld,
  input  logic [NA-1:0][IDX_W-1:0]        addr_idx,
  input  logic [NA-1:0][ADDR_W-1:0]       addr_val,
  input  logic [NI-1:0]                   int_vld,
  input  logic [NI-1:0][IDX_W-1:0]        int_idx,
  input  logic [NI-1:0][LANE_W-1:0]       int_lane,
  input  logic [NI-1:0][INT_BITS-1:0]     int_data,
  input  logic [NI-1:0][INT_BYTES-1:0]    int_be,
  input  logic [NM-1:0]                   med_vld,
  input  logic [NM-1:0][IDX_W-1:0]        med_idx,
  input  logic [NM-1:0][SLOT_BITS-1:0]    med_data,
  input  logic [NM-1:0][SLOT_BYTES-1:0]   med_be,
  input  logic [IDX_W-1:0]                head,
  input  logic [IDX_W-1:0]                head1,
  input  logic [1:0]                      commit_num,
  output logic                            rd0_rdy,
  output logic [LINE_W-1:0]               rd0_line,
  output logic                            rd0_half,
  output logic [SLOT_BITS-1:0]            rd0_data,
  output logic [SLOT_BYTES-1:0]           rd0_be,
  output logic                            rd1_rdy,
  output logic [LINE_W-1:0]               rd1_line,
  output logic                            rd1_half,
  output logic [SLOT_BITS-1:0]            rd1_data,
  output logic [SLOT_BYTES-1:0]           rd1_be
);

  logic [DEPTH-1:0]      av_q, av_d, dv_q, dv_d, awe, dwe;
  logic [DEPTH-1:0]      half_q, half_d;
  logic [LINE_W-1:0]     line_q [DEPTH];
  logic [LINE_W-1:0]     line_d [DEPTH];
  logic [SLOT_BITS-1:0]  data_q [DEPTH];
  logic [SLOT_BITS-1:0]  data_d [DEPTH];
  logic [SLOT_BYTES-1:0] be_q   [DEPTH];
  logic [SLOT_BYTES-1:0] be_d   [DEPTH];

  always_comb begin
    av_d   = av_q;
    dv_d   = dv_q;
    half_d = half_q;
    awe    = '0;
    dwe    = '0;
    for (int e = 0; e < DEPTH; e++) begin
      line_d[e] = line_q[e];
      data_d[e] = data_q[e];
      be_d[e]   = be_q[e];
    end
    for (int p = 0; p < NA; p++) begin
      if (addr_vld[p]) begin
        av_d[addr_idx[p]]   = 1'b1;
        awe[addr_idx[p]]    = 1'b1;
        line_d[addr_idx[p]] = addr_val[p][ADDR_W-1:LINE_LSB];
        half_d[addr_idx[p]] = addr_val[p][HALF_LSB];
      end
    end
    for (int p = 0; p < NI; p++) begin
      if (int_vld[p]) begin
        dv_d[int_idx[p]] = 1'b1;
        dwe[int_idx[p]]  = 1'b1;
        data_d[int_idx[p]] = '0;
        data_d[int_idx[p]][int_lane[p]*INT_BITS +: INT_BITS] = int_data[p];
        be_d[int_idx[p]] = '0;
        be_d[int_idx[p]][int_lane[p]*INT_BYTES +: INT_BYTES] = int_be[p];
      end
    end
    for (int p = 0; p < NM; p++) begin
      if (med_vld[p]) begin
        dv_d[med_idx[p]]   = 1'b1;
        dwe[med_idx[p]]    = 1'b1;
        data_d[med_idx[p]] = med_data[p];
        be_d[med_idx[p]]   = med_be[p];
      end
    end
    av_d = av_d & ~alloc_clr;
    dv_d = dv_d & ~alloc_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av_q <= '0;
      dv_q <= '0;
    end else begin
      av_q <= av_d;
      dv_q <= dv_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (awe[e]) begin
        line_q[e] <= line_d[e];
        half_q[e] <= half_d[e];
      end
      if (dwe[e]) begin
        data_q[e] <= data_d[e];
        be_q[e]   <= be_d[e];
      end
    end
  end

  assign rd0_rdy  = av_q[head] & dv_q[head];
  assign rd0_line = line_q[head];
  assign rd0_half = half_q[head];
  assign rd0_data = data_q[head];
  assign rd0_be   = be_q[head];
  assign rd1_rdy  = av_q[head1] & dv_q[head1];
  assign rd1_line = line_q[head1];
  assign rd1_half = half_q[head1];
  assign rd1_data = data_q[head1];
  assign rd1_be   = be_q[head1];

  // R3: whatever drains has both its address and data in place
  a_r3_commit_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_num != 2'd0) |-> (av_q[head] && dv_q[head]));
  // R5: a paired drain covers both halves of one line
  a_r5_pair_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_num == 2'd2) |-> (line_q[head] == line_q[head1]) && (half_q[head] != half_q[head1]));

endmodule

// File: rtl/sbm_commit.sv
module sbm_commit import sbm_pkg::*; #(
  parameter  int DEPTH  = 44,
  parameter  int ADDR_W = 48,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LINE_W = ADDR_W - LINE_LSB
) (
  input  logic [CNT_W-1:0]      ret_cnt,
  input  logic                  rd0_rdy,
  input  logic [LINE_W-1:0]     rd0_line,
  input  logic                  rd0_half,
  input  logic [SLOT_BITS-1:0]  rd0_data,
  input  logic [SLOT_BYTES-1:0] rd0_be,
  input  logic                  rd1_rdy,
  input  logic [LINE_W-1:0]     rd1_line,
  input  logic                  rd1_half,
  input  logic [SLOT_BITS-1:0]  rd1_data,
  input  logic [SLOT_BYTES-1:0] rd1_be,
  output logic [1:0]            commit_num,
  output logic                  cw_valid,
  output logic [LINE_W-1:0]     cw_line,
  output logic [LINE_BITS-1:0]  cw_data,
  output logic [LINE_BYTES-1:0] cw_be
);

  logic go0, pair;

  always_comb begin
    go0  = (ret_cnt >= CNT_W'(1)) && rd0_rdy;
    pair = go0 && (ret_cnt >= CNT_W'(2)) && rd1_rdy &&
           (rd1_line == rd0_line) && (rd1_half != rd0_half);
    commit_num = pair ? 2'd2 : (go0 ? 2'd1 : 2'd0);
    cw_valid   = go0;
    cw_line    = go0 ? rd0_line : '0;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_comb begin
      if (go0 && (rd0_half == h[0])) begin
        cw_data[h*SLOT_BITS +: SLOT_BITS]   = rd0_data;
        cw_be[h*SLOT_BYTES +: SLOT_BYTES]   = rd0_be;
      end else if (pair && (rd1_half == h[0])) begin
        cw_data[h*SLOT_BITS +: SLOT_BITS]   = rd1_data;
        cw_be[h*SLOT_BYTES +: SLOT_BYTES]   = rd1_be;
      end else begin
        cw_data[h*SLOT_BITS +: SLOT_BITS]   = '0;
        cw_be[h*SLOT_BYTES +: SLOT_BYTES]   = '0;
      end
    end
  end

endmodule

// File: rtl/stbuf_merge.sv
module stbuf_merge import sbm_pkg::*; #(
  parameter  int DEPTH   = 44,
  parameter  int ADDR_W  = 48,
  parameter  int NA      = 3,
  parameter  int NI      = 2,
  parameter  int NM      = 2,
  parameter  int ALLOC_W = 4,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int AN_W    = $clog2(ALLOC_W + 1),
  localparam int LINE_W  = ADDR_W - LINE_LSB
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AN_W-1:0]               alloc_num,
  output logic                          alloc_stall,
  output logic [IDX_W-1:0]              alloc_tail,
  output logic [CNT_W-1:0]              free_cnt,
  input  logic [AN_W-1:0]               retire_num,
  input  logic                          flush,
  input  logic [NA-1:0]                 addr_vld,
  input  logic [NA-1:0][IDX_W-1:0]      addr_idx,
  input  logic [NA-1:0][ADDR_W-1:0]     addr_val,
  input  logic [NI-1:0]                 int_vld,
  input  logic [NI-1:0][IDX_W-1:0]      int_idx,
  input  logic [NI-1:0][LANE_W-1:0]     int_lane,
  input  logic [NI-1:0][INT_BITS-1:0]   int_data,
  input  logic [NI-1:0][INT_BYTES-1:0]  int_be,
  input  logic [NM-1:0]                 med_vld,
  input  logic [NM-1:0][IDX_W-1:0]      med_idx,
  input  logic [NM-1:0][SLOT_BITS-1:0]  med_data,
  input  logic [NM-1:0][SLOT_BYTES-1:0] med_be,
  output logic                          cw_valid,
  output logic [LINE_W-1:0]             cw_line,
  output logic [LINE_BITS-1:0]          cw_data,
  output logic [LINE_BYTES-1:0]         cw_be
);

  logic [1:0]            rs_q;
  logic                  rst_i_n;
  logic [IDX_W-1:0]      head, head1;
  logic [CNT_W-1:0]      ret_cnt;
  logic [DEPTH-1:0]      alloc_clr;
  logic [1:0]            commit_num;
  logic                  rd0_rdy, rd1_rdy, rd0_half, rd1_half;
  logic [LINE_W-1:0]     rd0_line, rd1_line;
  logic [SLOT_BITS-1:0]  rd0_data, rd1_data;
  logic [SLOT_BYTES-1:0] rd0_be, rd1_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  sbm_ctrl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W)) u_ctrl (
    .clk, .rst_n(rst_i_n), .alloc_num, .retire_num, .flush, .commit_num,
    .head_o(head), .head1_o(head1), .tail_o(alloc_tail), .ret_cnt_o(ret_cnt),
    .free_o(free_cnt), .alloc_stall_o(alloc_stall), .alloc_clr_o(alloc_clr)
  );

  sbm_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NA(NA), .NI(NI), .NM(NM)) u_store (
    .clk, .rst_n(rst_i_n), .alloc_clr,
    .addr_vld, .addr_idx, .addr_val,
    .int_vld, .int_idx, .int_lane, .int_data, .int_be,
    .med_vld, .med_idx, .med_data, .med_be,
    .head, .head1, .commit_num,
    .rd0_rdy, .rd0_line, .rd0_half, .rd0_data, .rd0_be,
    .rd1_rdy, .rd1_line, .rd1_half, .rd1_data, .rd1_be
  );

  sbm_commit #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_commit (
    .ret_cnt,
    .rd0_rdy, .rd0_line, .rd0_half, .rd0_data, .rd0_be,
    .rd1_rdy, .rd1_line, .rd1_half, .rd1_data, .rd1_be,
    .commit_num, .cw_valid, .cw_line, .cw_data, .cw_be
  );

endmodule

// File: tb/stbuf_merge_test.sv
module stbuf_merge_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] alloc_num, retire_num;
  logic alloc_stall, flush;
  logic [5:0] alloc_tail, free_cnt;
  logic [2:0] addr_vld;
  logic [2:0][5:0] addr_idx;
  logic [2:0][47:0] addr_val;
  logic [1:0] int_vld;
  logic [1:0][5:0] int_idx;
  logic [1:0][1:0] int_lane;
  logic [1:0][63:0] int_data;
  logic [1:0][7:0] int_be;
  logic [1:0] med_vld;
  logic [1:0][5:0] med_idx;
  logic [1:0][255:0] med_data;
  logic [1:0][31:0] med_be;
  logic cw_valid;
  logic [41:0] cw_line;
  logic [511:0] cw_data;
  logic [63:0] cw_be;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stbuf_merge uut (
    .clk, .rst_n, .alloc_num, .alloc_stall, .alloc_tail, .free_cnt,
    .retire_num, .flush, .addr_vld, .addr_idx, .addr_val,
    .int_vld, .int_idx, .int_lane, .int_data, .int_be,
    .med_vld, .med_idx, .med_data, .med_be,
    .cw_valid, .cw_line, .cw_data, .cw_be
  );

  function automatic logic [47:0] mk_addr(input logic [41:0] ln, input logic h, input logic [4:0] lo);
    return {ln, h, lo};
  endfunction

  task automatic chk(input string req, input string what, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    alloc_num = '0; retire_num = '0; flush = 1'b0;
    addr_vld = '0; addr_idx = '0; addr_val = '0;
    int_vld = '0; int_idx = '0; int_lane = '0; int_data = '0; int_be = '0;
    med_vld = '0; med_idx = '0; med_data = '0; med_be = '0;
  endtask

  task automatic do_alloc(input int n, output int base);
    alloc_num = 3'(n);
    base = int'(alloc_tail);
    tick();
    alloc_num = '0;
  endtask

  task automatic set_addr(input int p, input int idx, input logic [47:0] a);
    addr_vld[p] = 1'b1; addr_idx[p] = 6'(idx); addr_val[p] = a;
  endtask

  task automatic set_med(input int p, input int idx, input logic [255:0] d, input logic [31:0] m);
    med_vld[p] = 1'b1; med_idx[p] = 6'(idx); med_data[p] = d; med_be[p] = m;
  endtask

  task automatic step_clear();
    tick();
    idle_in();
  endtask

  task automatic t_reset();
    chk("R1", "free_cnt", 512'(free_cnt), 512'(44));
    chk("R1", "alloc_tail", 512'(alloc_tail), 512'(0));
    chk("R1", "cw_valid", 512'(cw_valid), 512'(0));
    chk("R1", "alloc_stall", 512'(alloc_stall), 512'(0));
  endtask

  task automatic t_single();
    int b;
    logic [255:0] d = {8{32'hA1B2_0001}};
    logic [31:0]  m = 32'hF0F0_00FF;
    do_alloc(1, b);
    chk("R2", "first slot", 512'(b), 512'(0));
    chk("R10", "free after alloc", 512'(free_cnt), 512'(43));
    set_addr(0, b, mk_addr(42'h123, 1'b1, 5'h07));
    set_med(0, b, d, m);
    step_clear();
    chk("R3", "no commit before retire", 512'(cw_valid), 512'(0));
    retire_num = 3'd1;
    step_clear();
    chk("R4", "valid", 512'(cw_valid), 512'(1));
    chk("R4", "line", 512'(cw_line), 512'(42'h123));
    chk("R4", "be upper half", 512'(cw_be), 512'({m, 32'h0}));
    chk("R4", "data upper half", cw_data, {d, 256'h0});
    tick();
    chk("R10", "free after commit", 512'(free_cnt), 512'(44));
    chk("R4", "idle after commit", 512'(cw_valid), 512'(0));
  endtask

  task automatic t_pair();
    int b;
    logic [255:0] d2 = {8{32'h2222_0002}}, d3 = {8{32'h3333_0003}};
    logic [31:0]  m2 = 32'h0000_FFFF, m3 = 32'hFFFF_0001;
    do_alloc(2, b);
    set_addr(1, b, mk_addr(42'h456, 1'b0, 5'h0));
    set_addr(2, b + 1, mk_addr(42'h456, 1'b1, 5'h0));
    set_med(0, b, d2, m2);
    set_med(1, b + 1, d3, m3);
    step_clear();
    retire_num = 3'd2;
    step_clear();
    chk("R5", "pair valid", 512'(cw_valid), 512'(1));
    chk("R5", "pair be", 512'(cw_be), 512'({m3, m2}));
    chk("R5", "pair data", cw_data, {d3, d2});
    chk("R5", "free before drain", 512'(free_cnt), 512'(42));
    tick();
    chk("R5", "both freed in one cycle", 512'(free_cnt), 512'(44));
    chk("R5", "nothing left", 512'(cw_valid), 512'(0));
  endtask

  task automatic t_same_half();
    int b;
    logic [255:0] d4 = {8{32'h4444_0004}}, d5 = {8{32'h5555_0005}};
    do_alloc(2, b);
    set_addr(0, b, mk_addr(42'h77, 1'b0, 5'h0));
    set_addr(1, b + 1, mk_addr(42'h77, 1'b0, 5'h0));
    set_med(0, b, d4, 32'hFFFF_FFFF);
    set_med(1, b + 1, d5, 32'h0000_000F);
    step_clear();
    retire_num = 3'd2;
    step_clear();
    chk("R6", "same half first single", 512'(cw_be), 512'({32'h0, 32'hFFFF_FFFF}));
    chk("R6", "same half first data", cw_data, {256'h0, d4});
    tick();
    chk("R6", "same half second data", cw_data, {256'h0, d5});
    chk("R6", "free after first single", 512'(free_cnt), 512'(43));
    tick();
    chk("R6", "drained", 512'(cw_valid), 512'(0));
  endtask

  task automatic t_order();
    int b;
    logic [255:0] d6 = {8{32'h6666_0006}}, d7 = {8{32'h7777_0007}};
    do_alloc(2, b);
    set_addr(0, b, mk_addr(42'h200, 1'b1, 5'h0));
    set_addr(1, b + 1, mk_addr(42'h201, 1'b0, 5'h0));
    set_med(1, b + 1, d6, 32'h0000_00F0);
    step_clear();
    retire_num = 3'd2;
    step_clear();
    chk("R3", "younger waits for older", 512'(cw_valid), 512'(0));
    set_med(0, b, d7, 32'h8000_0000);
    step_clear();
    chk("R6", "different lines single line", 512'(cw_line), 512'(42'h200));
    chk("R6", "different lines single be", 512'(cw_be), 512'({32'h8000_0000, 32'h0}));
    tick();
    chk("R3", "then younger line", 512'(cw_line), 512'(42'h201));
    chk("R3", "then younger data", cw_data, {256'h0, d6});
    tick();
  endtask

  task automatic t_int_lane();
    int b;
    do_alloc(1, b);
    set_addr(0, b, mk_addr(42'h300, 1'b0, 5'h0));
    int_vld[0] = 1'b1; int_idx[0] = 6'(b); int_lane[0] = 2'd2;
    int_data[0] = 64'hDEAD_BEEF_0123_4567; int_be[0] = 8'h3C;
    retire_num = 3'd1;
    step_clear();
    chk("R7", "int lane be", 512'(cw_be), 512'(64'h3C << 16));
    chk("R7", "int lane data", cw_data, 512'(64'hDEAD_BEEF_0123_4567) << 128);
    tick();
  endtask

  task automatic t_full_flush();
    int b;
    logic [255:0] d8 = {8{32'h8888_0008}}, d9 = {8{32'h9999_0009}};
    for (int i = 0; i < 11; i++) do_alloc(4, b);
    chk("R2", "ring full", 512'(free_cnt), 512'(0));
    alloc_num = 3'd1;
    #1;
    chk("R2", "stall when full", 512'(alloc_stall), 512'(1));
    tick();
    alloc_num = '0;
    chk("R2", "tail held on stall", 512'(alloc_tail), 512'(8));
    chk("R2", "free held on stall", 512'(free_cnt), 512'(0));
    retire_num = 3'd2;
    step_clear();
    chk("R3", "retired but empty does not drain", 512'(cw_valid), 512'(0));
    flush = 1'b1;
    step_clear();
    chk("R8", "tail back after flush", 512'(alloc_tail), 512'(10));
    chk("R8", "free regained", 512'(free_cnt), 512'(42));
    set_addr(0, 8, mk_addr(42'h400, 1'b0, 5'h0));
    set_addr(1, 9, mk_addr(42'h400, 1'b1, 5'h0));
    set_med(0, 8, d8, 32'h1111_1111);
    set_med(1, 9, d9, 32'h2222_2222);
    step_clear();
    chk("R8", "retired survivors merge", 512'(cw_be), 512'({32'h2222_2222, 32'h1111_1111}));
    chk("R8", "retired survivors data", cw_data, {d9, d8});
    tick();
    chk("R8", "empty after drain", 512'(free_cnt), 512'(44));
  endtask

  task automatic t_wrap();
    int b;
    logic [255:0] da = {8{32'hAAAA_000A}}, db = {8{32'hBBBB_000B}};
    for (int i = 0; i < 33; i++) begin
      do_alloc(1, b);
      set_addr(0, b, mk_addr(42'(32'h500 + i), 1'b0, 5'h0));
      set_med(0, b, {8{32'(i)}}, 32'hFFFF_FFFF);
      retire_num = 3'd1;
      step_clear();
      chk("R9", "stream line", 512'(cw_line), 512'(32'h500 + i));
    end
    tick();
    chk("R9", "head at last slot", 512'(alloc_tail), 512'(43));
    do_alloc(2, b);
    chk("R9", "wrapped tail", 512'(alloc_tail), 512'(1));
    set_addr(0, 43, mk_addr(42'h600, 1'b1, 5'h0));
    set_addr(1, 0, mk_addr(42'h600, 1'b0, 5'h0));
    set_med(0, 43, da, 32'hAAAA_AAAA);
    set_med(1, 0, db, 32'h5555_5555);
    retire_num = 3'd2;
    step_clear();
    chk("R9", "pair across wrap be", 512'(cw_be), 512'({32'hAAAA_AAAA, 32'h5555_5555}));
    chk("R9", "pair across wrap data", cw_data, {da, db});
    tick();
    chk("R9", "drained after wrap", 512'(free_cnt), 512'(44));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_pair();
    t_same_half();
    t_order();
    t_int_lane();
    t_full_flush();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule